// File: doc/BRIEF.md
# Double-Rate RAM Port Expander

This block gives a compute engine two reads and two writes per system clock cycle from one plain memory that has a single write port and a single read port. The memory and the sequencing logic run on a clock at twice the system rate. Each system-cycle request names two locations: one on the "t side" and one on the "u side". The block turns each request into two back-to-back memory accesses in the fast domain.

A packed read request carries a t address and a u address. The two read results are gathered and returned as one packed response. A packed write request carries an address, data and enable for each side, and a side with its enable clear writes nothing. All three streams (read requests, write requests, read responses) use valid/ready handshakes. They cross between the two clock domains through small first-in first-out buffers. The two clocks come from one source and their rising edges line up, so these buffers need no synchronizers on their pointers. The read and write streams are independent of each other, so a read issued while a write to the same location is in flight may return either value.

Top module: `dp_ram_pump`

## Requirements
- R1: A read of any location returns the word most recently written there. Words are DATA_W bits wide and the memory holds 2^ADDR_W words.
- R2: In a write request, a side whose enable bit is 0 leaves its addressed word unchanged. The other side of the same request is still written if its enable is 1.
- R3: A read response places the word at the t address on `rd_rsp_tdata` and the word at the u address on `rd_rsp_udata`. This holds when the two addresses are equal and when the u address is lower than the t address.
- R4: Read responses leave in the same order as the read requests were accepted, one response per request.
- R5: Within each request, the t-side access reaches the memory one fast cycle before the u-side access. When a write request has equal addresses with both sides enabled, the u data remains in memory.
- R6: When both request streams are offered every system cycle and responses are taken every cycle, each request input accepts one request per system cycle without stalling.
- R7: While responses are not taken, the block accepts exactly 2×FIFO_DEPTH read requests and then holds `rd_req_ready` low. It loses no response and overfills no buffer.
- R8: After reset, `rd_req_ready` and `wr_req_ready` are 1 and `rd_rsp_valid` is 0.
- R9: While `rd_rsp_valid` is 1 and `rd_rsp_ready` is 0, the response data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_1x | input | 1 | System clock for all request and response handshakes |
| clk_2x | input | 1 | Memory clock, twice clk_1x, with rising edges aligned to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_valid | input | 1 | Packed read request offered |
| rd_req_ready | output | 1 | Packed read request accepted on this edge |
| rd_req_taddr | input | ADDR_W | t-side read address |
| rd_req_uaddr | input | ADDR_W | u-side read address |
| rd_rsp_valid | output | 1 | Packed read response available |
| rd_rsp_ready | input | 1 | Consumer takes the response |
| rd_rsp_tdata | output | DATA_W | Word read from the t address |
| rd_rsp_udata | output | DATA_W | Word read from the u address |
| wr_req_valid | input | 1 | Packed write request offered |
| wr_req_ready | output | 1 | Packed write request accepted on this edge |
| wr_req_taddr | input | ADDR_W | t-side write address |
| wr_req_tdata | input | DATA_W | t-side write data |
| wr_req_ten | input | 1 | t-side write enable |
| wr_req_uaddr | input | ADDR_W | u-side write address |
| wr_req_udata | input | DATA_W | u-side write data |
| wr_req_uen | input | 1 | u-side write enable |

## Verification
A scoreboard predicts every read result from a memory model that follows accepted writes. Reads are tried with strided pairs, with equal t and u addresses, and with the u address below the t address. Together these separate a swap of the response halves or a wrong address on one side from a correct result. Writes with one side disabled show whether an enable is ignored, and a same-address write pair shows which side is issued last. A continuous stream of both request kinds detects any lost throughput. Holding the response consumer off shows the credit limit and whether data stays put during a stall.

// File: rtl/dp_pump_pkg.sv
`timescale 1ns/1ps
package dp_pump_pkg;

  // Which half of a packed request the splitter is serving in the current fast cycle.
  typedef enum logic {
    PH_T = 1'b0,
    PH_U = 1'b1
  } pump_phase_e;

endpackage

// File: rtl/dp_xfifo.sv
`timescale 1ns/1ps
// Small FIFO between two edge-aligned clocks that come from one source.
// Pointers are read directly by the other side because edges coincide.
module dp_xfifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             w_valid,
  output logic             w_ready,
  input  logic [WIDTH-1:0] w_data,
  output logic [PTR_W:0]   w_count,
  input  logic             rclk,
  input  logic             rrst_n,
  output logic             r_valid,
  input  logic             r_ready,
  output logic [WIDTH-1:0] r_data
);

  localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W:0]   wptr_q;
  logic [PTR_W:0]   rptr_q;
  logic             w_push;
  logic             r_pop;

  always_comb begin
    w_count = wptr_q - rptr_q;
    w_ready = (w_count != FULL_CNT);
    w_push  = w_valid && w_ready;
    r_valid = (wptr_q != rptr_q);
    r_pop   = r_valid && r_ready;
    r_data  = store[rptr_q[PTR_W-1:0]];
  end

  always_ff @(posedge wclk) begin
    if (w_push) begin
      store[wptr_q[PTR_W-1:0]] <= w_data;
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wptr_q <= '0;
    end else if (w_push) begin
      wptr_q <= wptr_q + 1'b1;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rptr_q <= '0;
    end else if (r_pop) begin
      rptr_q <= rptr_q + 1'b1;
    end
  end

  // R9: an offered item that is not taken stays valid with the same data
  a_r9_hold_stable: assert property (@(posedge rclk) disable iff (!rrst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data)));

endmodule

// File: rtl/dp_ram.sv
`timescale 1ns/1ps
// One write port, one read port, registered read (one clock of latency).
module dp_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= cells[raddr];
    end
  end

endmodule

// File: rtl/dp_rd_split.sv
`timescale 1ns/1ps
// Turns one packed read into two memory reads (t, then u) and regathers them.
module dp_rd_split
  import dp_pump_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_taddr,
  input  logic [ADDR_W-1:0] req_uaddr,
  output logic              req_pop,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [CNT_W-1:0]  rsp_count,
  output logic              rsp_push,
  output logic [DATA_W-1:0] rsp_tdata,
  output logic [DATA_W-1:0] rsp_udata
);

  localparam logic [CNT_W:0] DEPTH_X = (CNT_W+1)'(DEPTH);

  pump_phase_e       phase_q, phase_d;
  logic              t_pend_q;
  logic              u_pend_q;
  logic [DATA_W-1:0] t_hold_q;
  logic [CNT_W:0]    committed;
  logic              room;
  logic              start;

  always_comb begin
    rsp_push  = u_pend_q;
    committed = {1'b0, rsp_count} + {{CNT_W{1'b0}}, rsp_push};
    room      = committed < DEPTH_X;
    start     = (phase_q == PH_T) && req_valid && room;
    ram_re    = start || (phase_q == PH_U);
    ram_raddr = (phase_q == PH_U) ? req_uaddr : req_taddr;
    req_pop   = (phase_q == PH_U);
    phase_d   = start ? PH_U : PH_T;
    rsp_tdata = t_hold_q;
    rsp_udata = ram_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_T;
      t_pend_q <= 1'b0;
      u_pend_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      t_pend_q <= start;
      u_pend_q <= (phase_q == PH_U);
    end
  end

  always_ff @(posedge clk) begin
    if (t_pend_q) begin
      t_hold_q <= ram_rdata;
    end
  end

  // R5: the u read of the same request follows the t read in the next fast cycle
  a_r5_rd_u_follows_t: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ram_re && req_valid && $stable(req_uaddr) && $stable(req_taddr)));

  // R7: the credit check never lets a response land in a full buffer
  a_r7_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_push |-> (rsp_count < DEPTH_X[CNT_W-1:0] || DEPTH_X[CNT_W]));

endmodule

// File: rtl/dp_wr_split.sv
`timescale 1ns/1ps
// Turns one packed write into two memory writes (t, then u), each gated by its enable.
module dp_wr_split
  import dp_pump_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_taddr,
  input  logic [DATA_W-1:0] req_tdata,
  input  logic              req_ten,
  input  logic [ADDR_W-1:0] req_uaddr,
  input  logic [DATA_W-1:0] req_udata,
  input  logic              req_uen,
  output logic              req_pop,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata
);

  pump_phase_e phase_q, phase_d;
  logic        start;

  always_comb begin
    start     = (phase_q == PH_T) && req_valid;
    req_pop   = (phase_q == PH_U);
    ram_waddr = (phase_q == PH_U) ? req_uaddr : req_taddr;
    ram_wdata = (phase_q == PH_U) ? req_udata : req_tdata;
    if (phase_q == PH_U) begin
      ram_we = req_uen;
    end else begin
      ram_we = start && req_ten;
    end
    phase_d = start ? PH_U : PH_T;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_T;
    end else begin
      phase_q <= phase_d;
    end
  end

  // R5: the u write of a request is issued in the fast cycle after its t write
  a_r5_wr_u_follows_t: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (req_valid && $stable(req_uaddr) && $stable(req_uen) && $stable(req_udata)));

endmodule

// File: rtl/dp_ram_pump.sv
`timescale 1ns/1ps
module dp_ram_pump #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk_1x,
  input  logic              clk_2x,
  input  logic              rst_n,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ADDR_W-1:0] rd_req_taddr,
  input  logic [ADDR_W-1:0] rd_req_uaddr,
  output logic              rd_rsp_valid,
  input  logic              rd_rsp_ready,
  output logic [DATA_W-1:0] rd_rsp_tdata,
  output logic [DATA_W-1:0] rd_rsp_udata,
  input  logic              wr_req_valid,
  output logic              wr_req_ready,
  input  logic [ADDR_W-1:0] wr_req_taddr,
  input  logic [DATA_W-1:0] wr_req_tdata,
  input  logic              wr_req_ten,
  input  logic [ADDR_W-1:0] wr_req_uaddr,
  input  logic [DATA_W-1:0] wr_req_udata,
  input  logic              wr_req_uen
);

  localparam int CNT_W   = $clog2(FIFO_DEPTH) + 1;
  localparam int RQ_W    = 2 * ADDR_W;
  localparam int HALF_W  = ADDR_W + DATA_W + 1;
  localparam int WQ_W    = 2 * HALF_W;
  localparam int RSP_W   = 2 * DATA_W;

  // Reset: asserted at once, released on each clock's own edge.
  logic [1:0] sync_1x_q;
  logic [1:0] sync_2x_q;
  logic       rst_1x_n;
  logic       rst_2x_n;

  always_ff @(posedge clk_1x or negedge rst_n) begin
    if (!rst_n) sync_1x_q <= '0;
    else        sync_1x_q <= {sync_1x_q[0], 1'b1};
  end

  always_ff @(posedge clk_2x or negedge rst_n) begin
    if (!rst_n) sync_2x_q <= '0;
    else        sync_2x_q <= {sync_2x_q[0], 1'b1};
  end

  assign rst_1x_n = sync_1x_q[1];
  assign rst_2x_n = sync_2x_q[1];

  // Read request crossing
  logic [RQ_W-1:0]  rq_head;
  logic             rq_valid;
  logic             rq_pop;
  logic [CNT_W-1:0] unused_rq_cnt;

  dp_xfifo #(.WIDTH(RQ_W), .DEPTH(FIFO_DEPTH)) u_rq_fifo (
    .wclk    (clk_1x),
    .wrst_n  (rst_1x_n),
    .w_valid (rd_req_valid),
    .w_ready (rd_req_ready),
    .w_data  ({rd_req_taddr, rd_req_uaddr}),
    .w_count (unused_rq_cnt),
    .rclk    (clk_2x),
    .rrst_n  (rst_2x_n),
    .r_valid (rq_valid),
    .r_ready (rq_pop),
    .r_data  (rq_head)
  );

  // Write request crossing
  logic [WQ_W-1:0]  wq_head;
  logic             wq_valid;
  logic             wq_pop;
  logic [CNT_W-1:0] unused_wq_cnt;

  dp_xfifo #(.WIDTH(WQ_W), .DEPTH(FIFO_DEPTH)) u_wq_fifo (
    .wclk    (clk_1x),
    .wrst_n  (rst_1x_n),
    .w_valid (wr_req_valid),
    .w_ready (wr_req_ready),
    .w_data  ({wr_req_ten, wr_req_taddr, wr_req_tdata,
               wr_req_uen, wr_req_uaddr, wr_req_udata}),
    .w_count (unused_wq_cnt),
    .rclk    (clk_2x),
    .rrst_n  (rst_2x_n),
    .r_valid (wq_valid),
    .r_ready (wq_pop),
    .r_data  (wq_head)
  );

  // Memory and splitters in the fast domain
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic              ram_re;
  logic [ADDR_W-1:0] ram_raddr;
  logic [DATA_W-1:0] ram_rdata;

  dp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk_2x),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  dp_wr_split #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr_split (
    .clk       (clk_2x),
    .rst_n     (rst_2x_n),
    .req_valid (wq_valid),
    .req_taddr (wq_head[HALF_W+DATA_W +: ADDR_W]),
    .req_tdata (wq_head[HALF_W +: DATA_W]),
    .req_ten   (wq_head[WQ_W-1]),
    .req_uaddr (wq_head[DATA_W +: ADDR_W]),
    .req_udata (wq_head[0 +: DATA_W]),
    .req_uen   (wq_head[HALF_W-1]),
    .req_pop   (wq_pop),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata)
  );

  logic             rsp_push;
  logic [DATA_W-1:0] rsp_t;
  logic [DATA_W-1:0] rsp_u;
  logic [CNT_W-1:0] rsp_count;
  logic             unused_rsp_ready;
  logic [RSP_W-1:0] rsp_head;

  dp_rd_split #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rd_split (
    .clk       (clk_2x),
    .rst_n     (rst_2x_n),
    .req_valid (rq_valid),
    .req_taddr (rq_head[ADDR_W +: ADDR_W]),
    .req_uaddr (rq_head[0 +: ADDR_W]),
    .req_pop   (rq_pop),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .ram_rdata (ram_rdata),
    .rsp_count (rsp_count),
    .rsp_push  (rsp_push),
    .rsp_tdata (rsp_t),
    .rsp_udata (rsp_u)
  );

  // Response crossing back to the system clock
  dp_xfifo #(.WIDTH(RSP_W), .DEPTH(FIFO_DEPTH)) u_rsp_fifo (
    .wclk    (clk_2x),
    .wrst_n  (rst_2x_n),
    .w_valid (rsp_push),
    .w_ready (unused_rsp_ready),
    .w_data  ({rsp_t, rsp_u}),
    .w_count (rsp_count),
    .rclk    (clk_1x),
    .rrst_n  (rst_1x_n),
    .r_valid (rd_rsp_valid),
    .r_ready (rd_rsp_ready),
    .r_data  (rsp_head)
  );

  assign rd_rsp_tdata = rsp_head[DATA_W +: DATA_W];
  assign rd_rsp_udata = rsp_head[0 +: DATA_W];

endmodule

// File: tb/test_dp_ram_pump.sv
`timescale 1ns/1ps
module test_dp_ram_pump;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int FD = 16;

  logic          clk_1x, clk_2x, rst_n;
  logic          rd_req_valid, rd_req_ready;
  logic [AW-1:0] rd_req_taddr, rd_req_uaddr;
  logic          rd_rsp_valid, rd_rsp_ready;
  logic [DW-1:0] rd_rsp_tdata, rd_rsp_udata;
  logic          wr_req_valid, wr_req_ready;
  logic [AW-1:0] wr_req_taddr, wr_req_uaddr;
  logic [DW-1:0] wr_req_tdata, wr_req_udata;
  logic          wr_req_ten, wr_req_uen;

  dp_ram_pump #(.ADDR_W(AW), .DATA_W(DW), .FIFO_DEPTH(FD)) i_dp_ram_pump (
    .clk_1x(clk_1x), .clk_2x(clk_2x), .rst_n(rst_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_taddr(rd_req_taddr), .rd_req_uaddr(rd_req_uaddr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_tdata(rd_rsp_tdata), .rd_rsp_udata(rd_rsp_udata),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
    .wr_req_taddr(wr_req_taddr), .wr_req_tdata(wr_req_tdata), .wr_req_ten(wr_req_ten),
    .wr_req_uaddr(wr_req_uaddr), .wr_req_udata(wr_req_udata), .wr_req_uen(wr_req_uen)
  );

  // 200 MHz memory clock; system clock at half rate with aligned rising edges
  initial begin
    clk_2x = 1'b0;
    forever #2.5 clk_2x = ~clk_2x;
  end
  initial begin
    clk_1x = 1'b0;
    #2.5;
    forever begin
      clk_1x = 1'b1; #5;
      clk_1x = 1'b0; #5;
    end
  end

  int n_chk;
  int n_fail;
  int rd_acc;
  int rd_stall;
  int wr_stall;
  int rsp_cnt;
  string tag;
  logic [DW-1:0]   model [1<<AW];
  logic [2*DW-1:0] exp_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return (32'h1357_0000 + 32'(a) * 32'h0001_0101) ^ (32'(salt) << 20);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk_1x);
  endtask

  // Driver: offers one read request, records the prediction when accepted
  task automatic send_rd(input int ta, input int ua);
    @(negedge clk_1x); #1;
    rd_req_valid = 1'b1;
    rd_req_taddr = AW'(ta);
    rd_req_uaddr = AW'(ua);
    while (!rd_req_ready) begin
      rd_stall++;
      @(negedge clk_1x); #1;
    end
    exp_q.push_back({model[ta], model[ua]});
    rd_acc++;
  endtask

  task automatic rd_idle();
    @(negedge clk_1x); #1;
    rd_req_valid = 1'b0;
  endtask

  task automatic send_wr(input int ta, input logic [DW-1:0] td, input bit te,
                         input int ua, input logic [DW-1:0] ud, input bit ue);
    @(negedge clk_1x); #1;
    wr_req_valid = 1'b1;
    wr_req_taddr = AW'(ta); wr_req_tdata = td; wr_req_ten = te;
    wr_req_uaddr = AW'(ua); wr_req_udata = ud; wr_req_uen = ue;
    while (!wr_req_ready) begin
      wr_stall++;
      @(negedge clk_1x); #1;
    end
    if (te) model[ta] = td;
    if (ue) model[ua] = ud;
  endtask

  task automatic wr_idle();
    @(negedge clk_1x); #1;
    wr_req_valid = 1'b0;
  endtask

  // Monitor: compares each taken response with the oldest prediction (R4 order)
  initial begin
    forever begin
      @(negedge clk_1x); #1;
      if (rst_n && rd_rsp_valid && rd_rsp_ready) begin
        rsp_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "response with no request", {rd_rsp_tdata, rd_rsp_udata}, 64'h0);
        end else begin
          logic [2*DW-1:0] e;
          e = exp_q.pop_front();
          check(rd_rsp_tdata == e[DW +: DW], tag, "t half", 64'(rd_rsp_tdata), 64'(e[DW +: DW]));
          check(rd_rsp_udata == e[0 +: DW], tag, "u half", 64'(rd_rsp_udata), 64'(e[0 +: DW]));
        end
      end
    end
  end

  initial begin
    #400000;
    check(1'b0, "watchdog", "run did not finish", 64'h0, 64'h1);
    report();
    $finish;
  end

  initial begin
    logic [DW-1:0] held_t, held_u;
    int rsp_base;
    n_chk = 0; n_fail = 0; rd_acc = 0; rd_stall = 0; wr_stall = 0; rsp_cnt = 0;
    tag = "R1";
    rst_n = 1'b0;
    rd_req_valid = 1'b0; rd_req_taddr = '0; rd_req_uaddr = '0; rd_rsp_ready = 1'b1;
    wr_req_valid = 1'b0; wr_req_taddr = '0; wr_req_uaddr = '0;
    wr_req_tdata = '0; wr_req_udata = '0; wr_req_ten = 1'b0; wr_req_uen = 1'b0;
    #23 rst_n = 1'b1;
    idle(5); #1;

    // R8: reset state
    check(rd_req_ready == 1'b1, "R8", "rd_req_ready", 64'(rd_req_ready), 64'h1);
    check(wr_req_ready == 1'b1, "R8", "wr_req_ready", 64'(wr_req_ready), 64'h1);
    check(rd_rsp_valid == 1'b0, "R8", "rd_rsp_valid", 64'(rd_rsp_valid), 64'h0);

    // R1: fill every location, then read strided pairs
    for (int i = 0; i < (1 << (AW-1)); i++)
      send_wr(2*i, pat(2*i, 1), 1'b1, 2*i+1, pat(2*i+1, 1), 1'b1);
    wr_idle();
    idle(10);
    tag = "R1";
    for (int i = 0; i < 32; i++) send_rd(i*3, 1023 - i*5);
    rd_idle();
    idle(20);

    // R3: equal addresses, u below t, extremes
    tag = "R3";
    send_rd(7, 7);
    send_rd(0, 1023);
    send_rd(1023, 0);
    send_rd(900, 5);
    send_rd(5, 900);
    rd_idle();
    idle(20);

    // R2: one side disabled in each request
    tag = "R2";
    send_wr(100, pat(100, 7), 1'b1, 101, pat(101, 7), 1'b0);
    send_wr(200, pat(200, 7), 1'b0, 201, pat(201, 7), 1'b1);
    wr_idle();
    idle(10);
    send_rd(100, 101);
    send_rd(200, 201);
    rd_idle();
    idle(20);

    // R5: same address on both sides, u issued last must win
    tag = "R5";
    send_wr(300, pat(300, 9), 1'b1, 300, pat(300, 11), 1'b1);
    wr_idle();
    idle(10);
    check(model[300] == pat(300, 11), "R5", "model u wins", 64'(model[300]), 64'(pat(300, 11)));
    send_rd(300, 300);
    rd_idle();
    idle(20);

    // R6: reads and writes streamed together every system cycle
    tag = "R6";
    rd_stall = 0; wr_stall = 0;
    fork
      begin
        for (int i = 0; i < 64; i++) send_rd(i, 511 - i);
        rd_idle();
      end
      begin
        for (int i = 0; i < 64; i++)
          send_wr(512 + 2*i, pat(512 + 2*i, 3), 1'b1, 513 + 2*i, pat(513 + 2*i, 3), 1'b1);
        wr_idle();
      end
    join
    check(rd_stall == 0, "R6", "read stalls", 64'(rd_stall), 64'h0);
    check(wr_stall == 0, "R6", "write stalls", 64'(wr_stall), 64'h0);
    idle(20);
    tag = "R1";
    for (int i = 0; i < 8; i++) send_rd(512 + i, 639 - i);
    rd_idle();
    idle(30);

    // R7: consumer held off, credit limit and lossless drain
    tag = "R7";
    @(negedge clk_1x); #0.5;
    rd_rsp_ready = 1'b0;
    rd_acc = 0;
    rsp_base = rsp_cnt;
    fork
      begin
        for (int i = 0; i < 40; i++) send_rd(40 + i, 700 + 3*i);
        rd_idle();
      end
    join_none
    idle(80); #1;
    check(rd_acc == 2*FD, "R7", "accepted while stalled", 64'(rd_acc), 64'(2*FD));
    check(rd_req_ready == 1'b0, "R7", "rd_req_ready held low", 64'(rd_req_ready), 64'h0);
    check(rsp_cnt == rsp_base, "R7", "no response taken", 64'(rsp_cnt), 64'(rsp_base));
    check(rd_rsp_valid == 1'b1, "R9", "response offered", 64'(rd_rsp_valid), 64'h1);
    held_t = rd_rsp_tdata;
    held_u = rd_rsp_udata;
    idle(5); #1;
    check(rd_rsp_tdata == held_t && rd_rsp_udata == held_u, "R9", "data held",
          {rd_rsp_tdata, rd_rsp_udata}, {held_t, held_u});
    check({rd_rsp_tdata, rd_rsp_udata} == exp_q[0], "R9", "held data is oldest",
          {rd_rsp_tdata, rd_rsp_udata}, exp_q[0]);
    @(negedge clk_1x); #0.5;
    rd_rsp_ready = 1'b1;
    wait fork;
    idle(60);
    check(rsp_cnt - rsp_base == 40, "R7", "responses after release", 64'(rsp_cnt - rsp_base), 64'd40);
    check(exp_q.size() == 0, "R4", "predictions left over", 64'(exp_q.size()), 64'h0);

    report();
    $finish;
  end

endmodule